// File: doc/BRIEF.md
# Per-Path Protection Switch Selector

This block sits inside a time-division switch fabric and decides, path by path, whether the fabric should take traffic from the working copy or from the protect copy of that path. It receives a time-multiplexed stream with one entry per clock cycle. Each entry carries a slot number and two 4-bit worst-case error codes, one for each copy. A larger code means a more severe condition, and code 0 means the copy is clean. The block keeps selection state, a preferred-copy bit, a wait-to-restore counter and an override setting for each of 48 path slots.

The block has two modes. In path-switched ring mode it moves each path's select bit by itself, with no processor involved, and the select bits drive the switch map directly. In line-switched ring mode it never changes a select bit. Instead it compares the codes and places every change of the preferred copy into a small status queue, and software reads that queue to set the switch. One entry is handled per cycle, so a single fault that hits every path is fully evaluated within one frame of 48 entries. That is far inside a 50 ms restoration budget.

Top module: `prot_sel_top`

## Requirements
- R1: After reset, every bit of `sel_map_o` is 0 (working copy), `irq_o` is 0 and `stat_valid_o` is 0.
- R2: In path-switched mode (`ring_mode_i`=0) with override 0, a path on the working copy moves to protect when the protect code is strictly lower than the working code. `sel_map_o[slot]` reflects the result in the cycle after the entry is accepted.
- R3: When the two codes are equal, the current selection of the path is kept.
- R4: A path on protect returns to working only on the Nth consecutive entry of that slot with the working code strictly lower, where N = `wtr_frames_i` (0 or 1 means at once). Any entry of that slot whose working code is not strictly lower restarts the count.
- R5: Override codes are written per slot through `ovr_we_i`, with 0 = automatic, 1 = force protect, and 2 or 3 = lockout (force working). In path-switched mode an override takes priority over the code comparison when that slot's next entry arrives.
- R6: In line-switched mode (`ring_mode_i`=1), entries never change `sel_map_o`.
- R7: In line-switched mode, each change of a slot's preferred copy (which uses the same strict-lower, keep-on-equal rule) pushes {slot, working code, protect code} into the status queue. The queue head is shown on `stat_*_o`, `irq_o` is 1 while the queue is not empty, and `stat_pop_i` removes the head.
- R8: The status queue holds 8 entries. A push while it is full and not being popped is dropped, and the stored entries are kept in order.
- R9: An entry with `valid_i`=0, or with a slot number of 48 or more, changes neither `sel_map_o` nor the status queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_mode_i | input | 1 | 0 = autonomous path-switched, 1 = report-only line-switched |
| wtr_frames_i | input | 8 | Wait-to-restore length in visits of the slot |
| valid_i | input | 1 | Entry present this cycle |
| slot_i | input | 6 | Slot number of the entry |
| work_code_i | input | 4 | Error code of the working copy |
| prot_code_i | input | 4 | Error code of the protect copy |
| ovr_we_i | input | 1 | Write the override of one slot |
| ovr_slot_i | input | 6 | Slot of the override write |
| ovr_val_i | input | 2 | Override value (0 auto, 1 force protect, 2/3 lockout) |
| sel_map_o | output | 48 | Per-slot select, 1 = protect copy |
| stat_pop_i | input | 1 | Remove the head of the status queue |
| stat_valid_o | output | 1 | Status queue head is valid |
| stat_slot_o | output | 6 | Slot at the queue head |
| stat_work_o | output | 4 | Working code at the queue head |
| stat_prot_o | output | 4 | Protect code at the queue head |
| irq_o | output | 1 | Status queue not empty |

## Verification
The hardest states to reach from the ports are the queue overflow and the restart of the wait-to-restore count. The bench makes one slot alternate its preferred copy ten times in a row to overfill the queue, then drains it and checks both the order of the entries and that the extra pushes were dropped. Table rows drive one slot through a partial restore interval, a degrade with equal codes and a full interval, so the switch back to working happens on exactly the visit the count predicts.

// File: rtl/prot_sel_pkg.sv
`timescale 1ns/1ps
package prot_sel_pkg;
  typedef enum logic [1:0] {
    OVR_AUTO       = 2'd0,
    OVR_FORCE_PROT = 2'd1,
    OVR_LOCKOUT    = 2'd2,
    OVR_LOCKOUT_B  = 2'd3
  } ovr_e;
endpackage

// File: rtl/prot_sel_decide.sv
`timescale 1ns/1ps
module prot_sel_decide
  import prot_sel_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int WTR_W  = 8
) (
  input  logic              report_i,
  input  ovr_e              ovr_i,
  input  logic              sel_i,
  input  logic              pref_i,
  input  logic [WTR_W-1:0]  wtr_i,
  input  logic [WTR_W-1:0]  wtr_cfg_i,
  input  logic [CODE_W-1:0] work_i,
  input  logic [CODE_W-1:0] prot_i,
  output logic              sel_o,
  output logic              pref_o,
  output logic [WTR_W-1:0]  wtr_o
);
  logic prot_better, work_better, wtr_done;
  logic [WTR_W:0] wtr_inc;

  assign prot_better = prot_i < work_i;
  assign work_better = work_i < prot_i;
  assign wtr_inc     = {1'b0, wtr_i} + 1'b1;
  assign wtr_done    = wtr_inc >= {1'b0, wtr_cfg_i};

  // preferred copy: strict improvement only, hold on tie
  always_comb begin
    pref_o = pref_i;
    if (!pref_i && prot_better) pref_o = 1'b1;
    if (pref_i && work_better)  pref_o = 1'b0;
  end

  always_comb begin
    sel_o = sel_i;
    wtr_o = wtr_i;
    if (!report_i) begin
      unique case (ovr_i)
        OVR_FORCE_PROT: begin sel_o = 1'b1; wtr_o = '0; end
        OVR_LOCKOUT, OVR_LOCKOUT_B: begin sel_o = 1'b0; wtr_o = '0; end
        default: begin
          if (!sel_i) begin
            wtr_o = '0;
            if (prot_better) sel_o = 1'b1;
          end else if (work_better) begin
            if (wtr_done) begin
              sel_o = 1'b0;
              wtr_o = '0;
            end else begin
              wtr_o = wtr_inc[WTR_W-1:0];
            end
          end else begin
            wtr_o = '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/prot_sel_fifo.sv
`timescale 1ns/1ps
module prot_sel_fifo #(
  parameter int DATA_W = 14,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, empty, do_push, do_pop;

  assign full    = cnt_q == CNT_W'(DEPTH);
  assign empty   = cnt_q == '0;
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  assign valid_o = !empty;
  assign data_o  = mem_q[rd_q];

  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && push_i && !pop_i |=> full && $stable(wr_q));

  // R7
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !empty && !push_i |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/prot_sel_state.sv
`timescale 1ns/1ps
module prot_sel_state
  import prot_sel_pkg::*;
#(
  parameter int NUM_SLOTS = 48,
  parameter int CODE_W    = 4,
  parameter int WTR_W     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              report_i,
  input  logic [WTR_W-1:0]  wtr_cfg_i,
  input  logic              valid_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [CODE_W-1:0] work_i,
  input  logic [CODE_W-1:0] prot_i,
  input  logic              ovr_we_i,
  input  logic [SLOT_W-1:0] ovr_slot_i,
  input  logic [1:0]        ovr_val_i,
  output logic [NUM_SLOTS-1:0] sel_map_o,
  output logic              push_o
);
  logic [NUM_SLOTS-1:0] sel_q, pref_q;
  logic [WTR_W-1:0]     wtr_q [NUM_SLOTS];
  ovr_e                 ovr_q [NUM_SLOTS];

  logic              hit;
  logic [SLOT_W-1:0] idx;
  logic              sel_n, pref_n;
  logic [WTR_W-1:0]  wtr_n;

  assign hit = valid_i && (32'(slot_i) < NUM_SLOTS);
  assign idx = hit ? slot_i : '0;

  prot_sel_decide #(.CODE_W(CODE_W), .WTR_W(WTR_W)) u_decide (
    .report_i  (report_i),
    .ovr_i     (ovr_q[idx]),
    .sel_i     (sel_q[idx]),
    .pref_i    (pref_q[idx]),
    .wtr_i     (wtr_q[idx]),
    .wtr_cfg_i (wtr_cfg_i),
    .work_i    (work_i),
    .prot_i    (prot_i),
    .sel_o     (sel_n),
    .pref_o    (pref_n),
    .wtr_o     (wtr_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      pref_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        wtr_q[i] <= '0;
        ovr_q[i] <= OVR_AUTO;
      end
    end else begin
      if (hit) begin
        sel_q[idx]  <= sel_n;
        pref_q[idx] <= pref_n;
        wtr_q[idx]  <= wtr_n;
      end
      if (ovr_we_i && 32'(ovr_slot_i) < NUM_SLOTS)
        ovr_q[ovr_slot_i] <= ovr_e'(ovr_val_i);
    end
  end

  assign push_o    = hit && report_i && (pref_n != pref_q[idx]);
  assign sel_map_o = sel_q;

  // R6
  report_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_i |=> $stable(sel_map_o));

  // R9
  ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(sel_map_o));

  // R5
  force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !report_i && ovr_q[idx] == OVR_FORCE_PROT |=> sel_map_o[$past(idx)]);

  // R5
  lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !report_i && ovr_q[idx][1] |=> !sel_map_o[$past(idx)]);

  // R3
  tie_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !report_i && ovr_q[idx] == OVR_AUTO && work_i == prot_i
      |=> $stable(sel_map_o));

  // R2
  to_prot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !report_i && ovr_q[idx] == OVR_AUTO && prot_i < work_i
      |=> sel_map_o[$past(idx)]);
endmodule

// File: rtl/prot_sel_top.sv
`timescale 1ns/1ps
module prot_sel_top #(
  parameter int NUM_SLOTS  = 48,
  parameter int CODE_W     = 4,
  parameter int WTR_W      = 8,
  parameter int STAT_DEPTH = 8,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int STAT_W    = SLOT_W + 2 * CODE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ring_mode_i,
  input  logic [WTR_W-1:0]     wtr_frames_i,
  input  logic                 valid_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [CODE_W-1:0]    work_code_i,
  input  logic [CODE_W-1:0]    prot_code_i,
  input  logic                 ovr_we_i,
  input  logic [SLOT_W-1:0]    ovr_slot_i,
  input  logic [1:0]           ovr_val_i,
  output logic [NUM_SLOTS-1:0] sel_map_o,
  input  logic                 stat_pop_i,
  output logic                 stat_valid_o,
  output logic [SLOT_W-1:0]    stat_slot_o,
  output logic [CODE_W-1:0]    stat_work_o,
  output logic [CODE_W-1:0]    stat_prot_o,
  output logic                 irq_o
);
  logic              push;
  logic [STAT_W-1:0] head;

  prot_sel_state #(
    .NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W), .WTR_W(WTR_W)
  ) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .report_i   (ring_mode_i),
    .wtr_cfg_i  (wtr_frames_i),
    .valid_i    (valid_i),
    .slot_i     (slot_i),
    .work_i     (work_code_i),
    .prot_i     (prot_code_i),
    .ovr_we_i   (ovr_we_i),
    .ovr_slot_i (ovr_slot_i),
    .ovr_val_i  (ovr_val_i),
    .sel_map_o  (sel_map_o),
    .push_o     (push)
  );

  prot_sel_fifo #(.DATA_W(STAT_W), .DEPTH(STAT_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  ({slot_i, work_code_i, prot_code_i}),
    .pop_i   (stat_pop_i),
    .valid_o (stat_valid_o),
    .data_o  (head)
  );

  assign {stat_slot_o, stat_work_o, stat_prot_o} = head;
  assign irq_o = stat_valid_o;

  // R9
  no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !stat_pop_i |=> $stable(stat_valid_o));
endmodule

// File: tb/tb_prot_sel_top.sv
`timescale 1ns/1ps
module tb_prot_sel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ring_mode = 1'b0;
  logic [7:0]  wtr = 8'd3;
  logic        valid = 1'b0;
  logic [5:0]  slot = '0;
  logic [3:0]  wc = '0, pc = '0;
  logic        ovr_we = 1'b0;
  logic [5:0]  ovr_slot = '0;
  logic [1:0]  ovr_val = '0;
  logic [47:0] sel_map;
  logic        pop = 1'b0;
  logic        st_valid, irq;
  logic [5:0]  st_slot;
  logic [3:0]  st_w, st_p;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  prot_sel_top dut (
    .clk_i(clk), .rst_ni(rst_n), .ring_mode_i(ring_mode), .wtr_frames_i(wtr),
    .valid_i(valid), .slot_i(slot), .work_code_i(wc), .prot_code_i(pc),
    .ovr_we_i(ovr_we), .ovr_slot_i(ovr_slot), .ovr_val_i(ovr_val),
    .sel_map_o(sel_map), .stat_pop_i(pop), .stat_valid_o(st_valid),
    .stat_slot_o(st_slot), .stat_work_o(st_w), .stat_prot_o(st_p), .irq_o(irq)
  );

  // {slot, work, prot, expected select}, auto mode, wtr = 3
  localparam logic [14:0] VEC [12] = '{
    {6'd5,  4'd0,  4'd0,  1'b0},  // R3 tie at reset state
    {6'd5,  4'd3,  4'd1,  1'b1},  // R2
    {6'd5,  4'd2,  4'd2,  1'b1},  // R3
    {6'd5,  4'd0,  4'd1,  1'b1},  // R4 count 1
    {6'd5,  4'd0,  4'd1,  1'b1},  // R4 count 2
    {6'd5,  4'd1,  4'd1,  1'b1},  // R4 restart
    {6'd5,  4'd0,  4'd2,  1'b1},
    {6'd5,  4'd0,  4'd2,  1'b1},
    {6'd5,  4'd0,  4'd2,  1'b0},  // R4 third visit reverts
    {6'd47, 4'd9,  4'd8,  1'b1},  // R2 top slot
    {6'd0,  4'd15, 4'd14, 1'b1},  // R2 slot 0
    {6'd0,  4'd14, 4'd15, 1'b1}   // R4 count 1 only
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic entry(input logic [5:0] s, input logic [3:0] w, input logic [3:0] p,
                       input logic v = 1'b1);
    slot = s; wc = w; pc = p; valid = v;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic set_ovr(input logic [5:0] s, input logic [1:0] v);
    ovr_slot = s; ovr_val = v; ovr_we = 1'b1;
    @(negedge clk);
    ovr_we = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(sel_map == '0, "R1 sel_map", int'(sel_map[31:0]), 0);
    chk(!irq && !st_valid, "R1 irq", int'(irq), 0);

    foreach (VEC[i]) begin
      logic [14:0] v;
      v = VEC[i];
      entry(v[14:9], v[8:5], v[4:1]);
      chk(sel_map[v[14:9]] == v[0], "R2/R3/R4 table", int'(sel_map[v[14:9]]), int'(v[0]));
    end

    // R9 out-of-range slot and idle entries
    snap = sel_map;
    entry(6'd50, 4'd9, 4'd0);
    chk(sel_map == snap, "R9 out-of-range slot", int'(sel_map[31:0]), int'(snap[31:0]));
    entry(6'd3, 4'd9, 4'd0, 1'b0);
    chk(sel_map[3] == 1'b0, "R9 valid low", int'(sel_map[3]), 0);

    // R5 overrides
    set_ovr(6'd7, 2'd1);
    entry(6'd7, 4'd0, 4'd9);
    chk(sel_map[7] == 1'b1, "R5 force protect", int'(sel_map[7]), 1);
    set_ovr(6'd7, 2'd2);
    entry(6'd7, 4'd9, 4'd0);
    chk(sel_map[7] == 1'b0, "R5 lockout", int'(sel_map[7]), 0);
    set_ovr(6'd7, 2'd3);
    entry(6'd7, 4'd9, 4'd0);
    chk(sel_map[7] == 1'b0, "R5 lockout alt", int'(sel_map[7]), 0);
    set_ovr(6'd7, 2'd0);
    entry(6'd7, 4'd9, 4'd0);
    chk(sel_map[7] == 1'b1, "R5 back to auto", int'(sel_map[7]), 1);

    // R4 wtr 0 reverts immediately
    wtr = 8'd0;
    entry(6'd7, 4'd0, 4'd9);
    chk(sel_map[7] == 1'b0, "R4 wtr zero", int'(sel_map[7]), 0);
    wtr = 8'd3;

    // R6 / R7 report mode
    ring_mode = 1'b1;
    snap = sel_map;
    entry(6'd20, 4'd5, 4'd1);
    chk(sel_map == snap, "R6 no select change", int'(sel_map[20]), int'(snap[20]));
    chk(irq && st_valid, "R7 irq raised", int'(irq), 1);
    chk(st_slot == 6'd20 && st_w == 4'd5 && st_p == 4'd1, "R7 head",
        int'({st_slot, st_w, st_p}), int'({6'd20, 4'd5, 4'd1}));
    entry(6'd50, 4'd9, 4'd0);
    do_pop();
    chk(!irq, "R9 out-of-range no push", int'(irq), 0);
    entry(6'd20, 4'd1, 4'd1);
    chk(!irq, "R7 tie no report", int'(irq), 0);

    // R8 overfill: 10 alternating changes on slot 30
    for (int k = 0; k < 10; k++) begin
      if (k % 2 == 0) entry(6'd30, 4'd5, 4'd1);
      else            entry(6'd30, 4'd1, 4'd5);
    end
    chk(sel_map[30] == 1'b0, "R6 slot 30 held", int'(sel_map[30]), 0);
    for (int k = 0; k < 8; k++) begin
      logic [3:0] ew;
      ew = (k % 2 == 0) ? 4'd5 : 4'd1;
      chk(st_valid && st_slot == 6'd30 && st_w == ew, "R8 order",
          int'(st_w), int'(ew));
      do_pop();
    end
    chk(!st_valid && !irq, "R8 extra dropped", int'(st_valid), 0);

    // R1 reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_map == '0 && !irq, "R1 reapplied", int'(sel_map[31:0]), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule